// File: doc/BRIEF.md
# Jumper-Addressed Control Register Bank

This block is the I/O-side register bank of a battery-backed memory expansion card. It watches a simple synchronous bus with one read strobe and one write strobe. It answers only inside an eight-byte window whose base address is set by two base-select jumper inputs, and the base can be one of four fixed values. Inside the window it returns fixed identification bytes, a revision byte, live LED status and the jumper settings. It also holds two writable configuration registers: a page number and a memory-mode byte.

The stored page number and the decoded mode fields leave the block as plain outputs, and the memory-window logic uses them. The block drives the two status LEDs from a supply-good input and a battery-warning input. It derives the data-bus width from a pair of width jumpers. If the two width jumpers disagree, the block reports a configuration error and falls back to 8-bit operation.

Top module: `cfg_reg_bank`

## Requirements
- R1: The window base is 0x140 plus 0x08 when `jmp_base[0]` is set, plus 0x20 when `jmp_base[1]` is set. The window covers the eight addresses from the base to base+7. An access outside the window asserts neither `io_hit` nor any register change.
- R2: Offset 0 reads 0x77, offset 1 reads 0xD9 and offset 2 reads 0x01.
- R3: Offset 3 reads `{6'b0, supply_good, batt_warn}`. `led_green` follows `supply_good` and `led_red` follows `batt_warn`.
- R4: Offset 4 is the page register. A write stores `io_wdata[5:0]`, a read returns `{2'b00, page}`, `page_num` shows the stored value, and reset clears it to 0.
- R5: Offset 5 is the mode register. Bit 7 is linear, bit 6 is paged, bit 5 is test, bit 4 is reserved and always reads 0, bit 3 is decode, and bits 2:0 are memory select. A write stores the other bits, each field drives its own output, and reset clears the register to 0.
- R6: Offset 6 reads `{2'b00, jmp_aux, jmp_width[1], 1'b0, jmp_base[1], jmp_base[0], 1'b0}`.
- R7: `jmp_width` = 2'b11 selects 8-bit mode (`bus_16bit`=0). `jmp_width` = 2'b00 selects 16-bit mode (`bus_16bit`=1). A mismatched pair sets `config_error`=1 with `bus_16bit`=0.
- R8: Writes to offsets 0, 1, 2, 3, 6 and 7 change nothing. Offset 7 reads 0.
- R9: Read data appears combinationally in the same cycle as `io_rd` with a matching address, and `io_hit` is asserted with it. Otherwise `io_rdata` is 0 and `io_hit` is 0.
- R10: The page and mode registers load on the clock edge that ends a write cycle. They hold their value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 12 | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when not selected |
| io_hit | output | 1 | Read strobe landed inside the window |
| jmp_base | input | 2 | Base-select jumpers, bit 0 and bit 1 |
| jmp_width | input | 2 | Width jumpers, bit 0 and bit 1 |
| jmp_aux | input | 1 | Spare jumper, reported only |
| supply_good | input | 1 | Main supply above threshold |
| batt_warn | input | 1 | Backup battery near end of life |
| led_green | output | 1 | Supply LED drive |
| led_red | output | 1 | Battery LED drive |
| page_num | output | 6 | Stored page number |
| mode_linear | output | 1 | Linear mapping enable |
| mode_paged | output | 1 | Paged window enable |
| mode_test | output | 1 | Factory test bit |
| mode_decode | output | 1 | Wide address decode select |
| mode_memsel | output | 3 | Memory window select |
| bus_16bit | output | 1 | 16-bit data mode |
| config_error | output | 1 | Width jumpers disagree |

## Verification
The bench moves the jumpers through all four base settings. For each setting it reads the window and also reads the neighbouring windows. A decoder that mixed up the two jumper weights would answer at the wrong base, and the cross-window reads expose that. Writing 0xFF to the page and mode registers exposes a design that keeps the upper page bits or the reserved mode bit. Writes to every read-only offset, and to a foreign window, expose a decoder that loads a register on a partial address match. Reading the bank with the strobe low exposes read data leaking onto the bus. The jumper readback is chosen so that any bit swapped between positions gives a different byte.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  localparam int unsigned OFF_W = 3;

  typedef enum logic [OFF_W-1:0] {
    OFF_ID0   = 3'd0,
    OFF_ID1   = 3'd1,
    OFF_REV   = 3'd2,
    OFF_LED   = 3'd3,
    OFF_PAGE  = 3'd4,
    OFF_MODE  = 3'd5,
    OFF_JMP   = 3'd6,
    OFF_SPARE = 3'd7
  } reg_off_e;

  typedef struct packed {
    logic       linear;
    logic       paged;
    logic       test;
    logic       rsvd;
    logic       decode;
    logic [2:0] memsel;
  } mode_t;

  // Base of the window: jumper bit 0 weighs 0x08, jumper bit 1 weighs 0x20.
  function automatic logic [11:0] io_base(input logic [1:0] jp);
    return 12'h140 | {6'b0, jp[1], 1'b0, jp[0], 3'b0};
  endfunction

  // Width jumpers: 2'b11 -> 8-bit, 2'b00 -> 16-bit, mismatch -> error.
  function automatic logic width_is_16(input logic [1:0] w);
    return (w == 2'b00);
  endfunction

  function automatic logic width_bad(input logic [1:0] w);
    return w[0] ^ w[1];
  endfunction

  // Mode byte with the reserved position forced to zero.
  function automatic mode_t mode_clean(input logic [7:0] b);
    mode_t m;
    m = mode_t'(b);
    m.rsvd = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        jp_base,
  input  logic              rd,
  input  logic              wr,
  output logic              rd_hit,
  output logic              wr_hit,
  output reg_off_e          off
);
  localparam int unsigned TAG_LSB = OFF_W;

  logic [ADDR_W-1:0] base_full;
  logic              in_window;

  assign base_full = ADDR_W'(io_base(jp_base));
  assign in_window = (addr[ADDR_W-1:TAG_LSB] == base_full[ADDR_W-1:TAG_LSB]);
  assign off       = reg_off_e'(addr[OFF_W-1:0]);
  assign rd_hit    = rd & in_window;
  assign wr_hit    = wr & in_window;
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_bank_pkg::*;
#(
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  reg_off_e          off,
  input  logic [DATA_W-1:0] wdata,
  output logic [PAGE_W-1:0] page_q,
  output mode_t             mode_q,
  output logic              wr_page_evt,
  output logic              wr_mode_evt
);
  assign wr_page_evt = wr_hit && (off == OFF_PAGE);
  assign wr_mode_evt = wr_hit && (off == OFF_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      mode_q <= '0;
    end else begin
      if (wr_page_evt) page_q <= wdata[PAGE_W-1:0];
      if (wr_mode_evt) mode_q <= mode_clean(wdata[7:0]);
    end
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_bank_pkg::*;
#(
  parameter int unsigned PAGE_W = 6,
  parameter logic [7:0]  ID0    = 8'h77,
  parameter logic [7:0]  ID1    = 8'hD9,
  parameter logic [7:0]  REV    = 8'h01
) (
  input  logic              rd_hit,
  input  reg_off_e          off,
  input  logic [PAGE_W-1:0] page_q,
  input  mode_t             mode_q,
  input  logic [7:0]        led_byte,
  input  logic [7:0]        jmp_byte,
  output logic [7:0]        rdata
);
  logic [7:0] sel;

  always_comb begin
    unique case (off)
      OFF_ID0:  sel = ID0;
      OFF_ID1:  sel = ID1;
      OFF_REV:  sel = REV;
      OFF_LED:  sel = led_byte;
      OFF_PAGE: sel = 8'(page_q);
      OFF_MODE: sel = mode_q;
      OFF_JMP:  sel = jmp_byte;
      default:  sel = 8'h00;
    endcase
  end

  assign rdata = rd_hit ? sel : 8'h00;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_hit,
  input  logic [1:0]        jmp_base,
  input  logic [1:0]        jmp_width,
  input  logic              jmp_aux,
  input  logic              supply_good,
  input  logic              batt_warn,
  output logic              led_green,
  output logic              led_red,
  output logic [PAGE_W-1:0] page_num,
  output logic              mode_linear,
  output logic              mode_paged,
  output logic              mode_test,
  output logic              mode_decode,
  output logic [2:0]        mode_memsel,
  output logic              bus_16bit,
  output logic              config_error
);
  // Named internal events, used by the bound checker.
  logic     rd_hit, wr_hit, wr_page_evt, wr_mode_evt;
  reg_off_e reg_off;
  mode_t    mode_q;
  logic [7:0] led_byte, jmp_byte;

  cfg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(io_addr), .jp_base(jmp_base), .rd(io_rd), .wr(io_wr),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .off(reg_off)
  );

  cfg_regs #(.PAGE_W(PAGE_W), .DATA_W(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .off(reg_off),
    .wdata(io_wdata), .page_q(page_num), .mode_q(mode_q),
    .wr_page_evt(wr_page_evt), .wr_mode_evt(wr_mode_evt)
  );

  assign led_green = supply_good;
  assign led_red   = batt_warn;
  assign led_byte  = {6'b0, led_green, led_red};
  assign jmp_byte  = {2'b00, jmp_aux, jmp_width[1], 1'b0, jmp_base[1], jmp_base[0], 1'b0};

  cfg_read_mux #(.PAGE_W(PAGE_W)) u_mux (
    .rd_hit(rd_hit), .off(reg_off), .page_q(page_num), .mode_q(mode_q),
    .led_byte(led_byte), .jmp_byte(jmp_byte), .rdata(io_rdata)
  );

  assign io_hit       = rd_hit;
  assign mode_linear  = mode_q.linear;
  assign mode_paged   = mode_q.paged;
  assign mode_test    = mode_q.test;
  assign mode_decode  = mode_q.decode;
  assign mode_memsel  = mode_q.memsel;
  assign config_error = width_bad(jmp_width);
  assign bus_16bit    = width_is_16(jmp_width);
endmodule

// File: rtl/cfg_reg_bank_chk.sv
module cfg_reg_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_rd,
  input logic       io_wr,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic       io_hit,
  input logic       rd_hit,
  input logic [2:0] reg_off,
  input logic       wr_page_evt,
  input logic       wr_mode_evt,
  input logic [5:0] page_num,
  input logic       mode_linear,
  input logic       mode_paged,
  input logic       mode_test,
  input logic       mode_decode,
  input logic [2:0] mode_memsel,
  input logic       supply_good,
  input logic       batt_warn,
  input logic       led_red,
  input logic       led_green,
  input logic [1:0] jmp_width,
  input logic       config_error,
  input logic       bus_16bit
);
  logic [7:0] mode_bus;
  assign mode_bus = {mode_linear, mode_paged, mode_test, 1'b0, mode_decode, mode_memsel};

  AST_LED_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (led_red == batt_warn) && (led_green == supply_good)); // R3
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && reg_off == 3'd3) |-> io_rdata == {6'b0, supply_good, batt_warn}); // R3
  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_page_evt |=> page_num == $past(io_wdata[5:0])); // R4
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode_evt |=> mode_bus == ($past(io_wdata) & 8'hEF)); // R5
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_page_evt |=> $stable(page_num)); // R10
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode_evt |=> $stable(mode_bus)); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !io_hit |-> io_rdata == 8'h00); // R9
  AST_HIT_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> io_rd); // R9
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && reg_off == 3'd7) |-> io_rdata == 8'h00); // R8
  AST_WIDTH_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_width[0] != jmp_width[1]) |-> (config_error && !bus_16bit)); // R7
  AST_WIDTH_16: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_width == 2'b00) |-> (bus_16bit && !config_error)); // R7
endmodule

bind cfg_reg_bank cfg_reg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
  .io_rdata(io_rdata), .io_hit(io_hit), .rd_hit(rd_hit), .reg_off(reg_off),
  .wr_page_evt(wr_page_evt), .wr_mode_evt(wr_mode_evt), .page_num(page_num),
  .mode_linear(mode_linear), .mode_paged(mode_paged), .mode_test(mode_test),
  .mode_decode(mode_decode), .mode_memsel(mode_memsel), .supply_good(supply_good),
  .batt_warn(batt_warn), .led_red(led_red), .led_green(led_green),
  .jmp_width(jmp_width), .config_error(config_error), .bus_16bit(bus_16bit)
);

// File: tb/cfg_reg_bank_tb.sv
module cfg_reg_bank_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [11:0] io_addr;
  logic        io_rd, io_wr;
  logic [7:0]  io_wdata, io_rdata;
  logic        io_hit;
  logic [1:0]  jmp_base, jmp_width;
  logic        jmp_aux, supply_good, batt_warn;
  logic        led_green, led_red;
  logic [5:0]  page_num;
  logic        mode_linear, mode_paged, mode_test, mode_decode;
  logic [2:0]  mode_memsel;
  logic        bus_16bit, config_error;

  cfg_reg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit),
    .jmp_base(jmp_base), .jmp_width(jmp_width), .jmp_aux(jmp_aux),
    .supply_good(supply_good), .batt_warn(batt_warn),
    .led_green(led_green), .led_red(led_red), .page_num(page_num),
    .mode_linear(mode_linear), .mode_paged(mode_paged), .mode_test(mode_test),
    .mode_decode(mode_decode), .mode_memsel(mode_memsel),
    .bus_16bit(bus_16bit), .config_error(config_error)
  );

  typedef struct { logic [7:0] d; logic h; string tag; } exp_t;
  exp_t exp_q[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // Bench's own view of the base table.
  function automatic logic [11:0] base_of(input logic [1:0] j);
    case (j)
      2'b00: return 12'h140;
      2'b01: return 12'h148;
      2'b10: return 12'h160;
      default: return 12'h168;
    endcase
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every read cycle, mid-cycle.
  always @(negedge clk) begin
    if (io_rd && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk({7'b0, io_hit, io_rdata}, {7'b0, e.h, e.d}, e.tag);
    end
  end

  task automatic rd(input logic [11:0] a, input logic [7:0] d, input logic h, input string tag);
    exp_t e;
    @(posedge clk); #1;
    io_addr = a; io_rd = 1'b1;
    e.d = d; e.h = h; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] b;
    rst_n = 0; io_addr = 0; io_rd = 0; io_wr = 0; io_wdata = 0;
    jmp_base = 2'b00; jmp_width = 2'b11; jmp_aux = 0;
    supply_good = 0; batt_warn = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // Reset state
    @(negedge clk);
    chk(16'(page_num), 16'h0, "R4 reset page_num");
    chk(16'({mode_linear, mode_paged, mode_test, mode_decode, mode_memsel}), 16'h0, "R5 reset mode");
    rd(12'h144, 8'h00, 1'b1, "R4 reset page read");
    rd(12'h145, 8'h00, 1'b1, "R5 reset mode read");

    // Base selection and ID bytes
    for (int j = 0; j < 4; j++) begin
      jmp_base = 2'(j);
      b = base_of(2'(j));
      rd(b + 12'd0, 8'h77, 1'b1, "R2 id0");
      rd(b + 12'd1, 8'hD9, 1'b1, "R2 id1");
      rd(b + 12'd2, 8'h01, 1'b1, "R2 rev");
      for (int k = 0; k < 4; k++)
        if (k != j) rd(base_of(2'(k)), 8'h00, 1'b0, "R1 foreign window");
      rd(b - 12'd1, 8'h00, 1'b0, "R1 below window");
      rd(b + 12'd8, 8'h00, 1'b0, "R1 above window");
    end
    jmp_base = 2'b00;

    // Strobe low gives nothing
    @(posedge clk); #1 io_addr = 12'h140;
    @(negedge clk);
    chk({7'b0, io_hit, io_rdata}, 16'h0, "R9 no strobe");

    // LED status
    for (int s = 0; s < 4; s++) begin
      supply_good = s[1]; batt_warn = s[0];
      rd(12'h143, {6'b0, s[1], s[0]}, 1'b1, "R3 status read");
      @(negedge clk);
      chk({14'b0, led_green, led_red}, 16'(s[1:0]), "R3 led pins");
    end

    // Page register
    wr(12'h144, 8'hFF);
    @(negedge clk);
    chk(16'(page_num), 16'h3F, "R4 page_num after 0xFF");
    rd(12'h144, 8'h3F, 1'b1, "R4 page read 0x3F");
    wr(12'h144, 8'h15);
    rd(12'h144, 8'h15, 1'b1, "R4 page read 0x15");

    // Mode register
    wr(12'h145, 8'hFF);
    @(negedge clk);
    chk(16'({mode_linear, mode_paged, mode_test, mode_decode, mode_memsel}), 16'h7F, "R5 mode pins 0xFF");
    rd(12'h145, 8'hEF, 1'b1, "R5 reserved bit reads 0");
    wr(12'h145, 8'h46);
    @(negedge clk);
    chk(16'({mode_linear, mode_paged, mode_test, mode_decode, mode_memsel}), 16'h26, "R5 mode pins 0x46");
    rd(12'h145, 8'h46, 1'b1, "R5 mode read 0x46");

    // Jumper register and width
    jmp_base = 2'b11; jmp_width = 2'b01; jmp_aux = 1;
    rd(12'h16E, 8'h26, 1'b1, "R6 jumper byte a");
    @(negedge clk);
    chk({14'b0, config_error, bus_16bit}, 16'h2, "R7 mismatch 01");
    jmp_base = 2'b01; jmp_width = 2'b10; jmp_aux = 0;
    rd(12'h14E, 8'h12, 1'b1, "R6 jumper byte b");
    @(negedge clk);
    chk({14'b0, config_error, bus_16bit}, 16'h2, "R7 mismatch 10");
    jmp_width = 2'b00;
    @(negedge clk);
    chk({14'b0, config_error, bus_16bit}, 16'h1, "R7 16-bit");
    jmp_width = 2'b11;
    @(negedge clk);
    chk({14'b0, config_error, bus_16bit}, 16'h0, "R7 8-bit");

    // Writes to read-only offsets and to a foreign window
    jmp_base = 2'b00;
    for (int o = 0; o < 8; o++)
      if (o != 4 && o != 5) wr(12'h140 + 12'(o), 8'hAA);
    wr(12'h14C, 8'h2A);
    wr(12'h16D, 8'h80);
    rd(12'h140, 8'h77, 1'b1, "R8 id0 kept");
    rd(12'h141, 8'hD9, 1'b1, "R8 id1 kept");
    rd(12'h142, 8'h01, 1'b1, "R8 rev kept");
    rd(12'h147, 8'h00, 1'b1, "R8 spare reads 0");
    rd(12'h144, 8'h15, 1'b1, "R10 page unchanged");
    rd(12'h145, 8'h46, 1'b1, "R10 mode unchanged");
    @(negedge clk);
    chk(16'(page_num), 16'h15, "R8 page_num unchanged");

    // Reset clears again
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(16'({page_num, mode_linear, mode_paged, mode_test, mode_decode, mode_memsel}), 16'h0, "R4 R5 second reset");

    repeat (2) @(negedge clk);
    chk(16'(exp_q.size()), 16'h0, "R9 scoreboard drained");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule